// File: doc/BRIEF.md
# RTC Prescaler and One-Second Update Timer

This block sits between the 32.768 kHz oscillator and the time-of-day counters of a real-time clock. It counts oscillator cycles in a 15-stage binary divider. From that divider it makes three things: a programmable square wave, a periodic tick at the same rate, and a one-cycle update strobe once per second. The strobe advances the time counters. A warning flag rises shortly before each strobe, so that software can tell when a read of the time registers is safe.

The oscillator is delivered as `osc_edge_i`, a one-cycle strobe in the system clock domain for each edge of the 32.768 kHz wave (65,536 strobes per second). An internal phase bit toggles on each strobe and rebuilds the 32.768 kHz wave. The divider advances once per oscillator period. A two-bit chain mode selects the state of the chain: stopped, running, or oscillating with the divider held at zero. These are the upper two bits of a three-bit control code; its lowest bit belongs to a neighbouring block and is not routed here. A freeze input lets software stop updates while it writes the time.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset all outputs are 0, the divider is at zero and the oscillator phase is stopped.
- R2: `chain_mode_i` = {hold_chain, osc_on}. Only 2'b01 (code 01X) advances the divider. Under 2'b11 (code 11X) the phase bit toggles but the divider stays at zero. Under any code other than 01X, `rate_tick_o`, `upd_strobe_o` and `upd_soon_o` stay 0.
- R3: With `raw32k_en_i` = 1, `sq_wave_o` follows the phase bit, toggling on every accepted strobe, whatever `tap_sel_i` and `sq_en_i` hold. With osc_on = 0 the phase bit is cleared and no toggling occurs.
- R4: `tap_sel_i` picks the divider bit b. Code 1 gives b=6 (256 Hz) and code 2 gives b=7 (128 Hz). Codes 3..15 give b = code-2 (8192 Hz down to 2 Hz). With `raw32k_en_i` = 0 and `sq_en_i` = 1, `sq_wave_o` equals bit b of the divider.
- R5: `rate_tick_o` pulses for one cycle each time bit b rises, independent of `sq_en_i`. With `tap_sel_i` = 0 there are no ticks and `sq_wave_o` is 0.
- R6: Divider count k after release from code 00X to 01X is reached 2k-1 cycles later when a strobe arrives every cycle. The first `upd_strobe_o` comes at count 16384 (half a second). Later strobes come every 32768 counts. Each strobe lasts one cycle.
- R7: `upd_soon_o` rises when the count reaches 8 below the update count (244 µs early). It falls in the cycle the update strobe is high.
- R8: While `freeze_i` = 1, no update strobe is issued. `upd_soon_o` is 0 one cycle after `freeze_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_edge_i | input | 1 | One strobe per edge of the 32.768 kHz oscillator |
| chain_mode_i | input | 2 | {hold_chain, osc_on} control of the chain |
| tap_sel_i | input | 4 | Divider tap select; 0 disables the tap |
| sq_en_i | input | 1 | Enables the tap onto the square-wave output |
| raw32k_en_i | input | 1 | Forces the 32.768 kHz wave onto the square-wave output |
| freeze_i | input | 1 | Blocks update strobes and clears the warning flag |
| sq_wave_o | output | 1 | Square-wave output |
| rate_tick_o | output | 1 | One-cycle periodic tick at the tap rate |
| upd_strobe_o | output | 1 | One-cycle once-per-second update strobe |
| upd_soon_o | output | 1 | Update-imminent warning flag |

## Verification
All registered results (tick, update strobe, warning flag, divider bits seen on the square wave) change on the clock edge that accepts the strobe. They are therefore due in the cycle after that strobe. With a strobe held every cycle from release, count k lands at cycle 2k-1. The first tick of tap b is due at cycle 2^(b+1)-1, the warning flag at 32751, the first update at 32767 and the second at 98303. The bench queues each of these cycle numbers before it releases the chain. A monitor samples on the falling edge and compares every watched event against the queue head. A missing, early, late or extra event is therefore a failure.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;

    localparam int unsigned SEL_W  = 4;
    localparam int unsigned MODE_W = 2;

    // Divider bit driven by a tap-select code (0 means no tap).
    function automatic int unsigned tap_bit(input logic [SEL_W-1:0] code);
        int unsigned b;
        case (code)
            4'd0:    b = 0;
            4'd1:    b = 6;
            4'd2:    b = 7;
            default: b = 32'(code) - 32'd2;
        endcase
        return b;
    endfunction

    typedef struct packed {
        logic phase;
    } osc_st_t;

    typedef struct packed {
        logic upd;
        logic soon;
    } upd_st_t;

    typedef struct packed {
        logic tick;
    } tap_st_t;

endpackage

// File: rtl/rtc_pre_osc.sv
module rtc_pre_osc
    import rtc_pre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_edge_i,
    input  logic [MODE_W-1:0] chain_mode_i,
    output logic              phase_o,
    output logic              run_o,
    output logic              adv_o
);

    osc_st_t st_d, st_q;
    logic    osc_on;

    always_comb begin
        osc_on = chain_mode_i[0];
        run_o  = (chain_mode_i == 2'b01);
        st_d   = st_q;
        if (!osc_on) begin
            st_d.phase = 1'b0;
        end else if (osc_edge_i) begin
            st_d.phase = ~st_q.phase;
        end
        // one divider count per full oscillator period
        adv_o = run_o && osc_edge_i && !st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

endmodule

// File: rtl/rtc_pre_div.sv
module rtc_pre_div #(
    parameter int unsigned STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              adv_i,
    output logic [STAGES-1:0] cnt_o,
    output logic [STAGES-1:0] cnt_nx_o
);

    logic [STAGES-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = cnt_q + STAGES'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_d;

endmodule

// File: rtl/rtc_pre_update.sv
module rtc_pre_update
    import rtc_pre_pkg::*;
#(
    parameter int unsigned STAGES   = 15,
    parameter int unsigned UIP_LEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              adv_i,
    input  logic              freeze_i,
    input  logic [STAGES-1:0] cnt_nx_i,
    output logic              upd_o,
    output logic              soon_o
);

    localparam logic [STAGES-1:0] UPD_AT  = STAGES'(1) << (STAGES - 1);
    localparam logic [STAGES-1:0] SOON_AT = UPD_AT - STAGES'(UIP_LEAD);

    upd_st_t st_d, st_q;
    logic    hit_upd, hit_soon;

    always_comb begin
        hit_upd  = run_i && adv_i && (cnt_nx_i == UPD_AT) && !freeze_i;
        hit_soon = run_i && adv_i && (cnt_nx_i == SOON_AT);
        st_d     = st_q;
        st_d.upd = hit_upd;
        if (!run_i || freeze_i || hit_upd) begin
            st_d.soon = 1'b0;
        end else if (hit_soon) begin
            st_d.soon = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upd_o  = st_q.upd;
    assign soon_o = st_q.soon;

endmodule

// File: rtl/rtc_pre_tap.sv
module rtc_pre_tap
    import rtc_pre_pkg::*;
#(
    parameter int unsigned STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] cnt_i,
    input  logic [STAGES-1:0] cnt_nx_i,
    input  logic [SEL_W-1:0]  tap_sel_i,
    input  logic              sq_en_i,
    input  logic              raw32k_en_i,
    input  logic              phase_i,
    output logic              sq_wave_o,
    output logic              tick_o
);

    localparam int IDX_W = $clog2(STAGES);

    tap_st_t          st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             active, tap_now, tap_nx;

    always_comb begin
        idx     = IDX_W'(tap_bit(tap_sel_i));
        active  = (tap_sel_i != '0);
        tap_now = cnt_i[idx];
        tap_nx  = cnt_nx_i[idx];
        st_d      = st_q;
        st_d.tick = active && !tap_now && tap_nx;
        if (raw32k_en_i) begin
            sq_wave_o = phase_i;
        end else begin
            sq_wave_o = sq_en_i && active && tap_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pre_pkg::*;
#(
    parameter int unsigned STAGES   = 15,
    parameter int unsigned UIP_LEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_edge_i,
    input  logic [MODE_W-1:0] chain_mode_i,
    input  logic [SEL_W-1:0]  tap_sel_i,
    input  logic              sq_en_i,
    input  logic              raw32k_en_i,
    input  logic              freeze_i,
    output logic              sq_wave_o,
    output logic              rate_tick_o,
    output logic              upd_strobe_o,
    output logic              upd_soon_o
);

    logic              phase, run, adv;
    logic [STAGES-1:0] cnt, cnt_nx;

    rtc_pre_osc i_osc (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_edge_i   (osc_edge_i),
        .chain_mode_i (chain_mode_i),
        .phase_o      (phase),
        .run_o        (run),
        .adv_o        (adv)
    );

    rtc_pre_div #(.STAGES(STAGES)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .adv_i    (adv),
        .cnt_o    (cnt),
        .cnt_nx_o (cnt_nx)
    );

    rtc_pre_update #(.STAGES(STAGES), .UIP_LEAD(UIP_LEAD)) i_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .adv_i    (adv),
        .freeze_i (freeze_i),
        .cnt_nx_i (cnt_nx),
        .upd_o    (upd_strobe_o),
        .soon_o   (upd_soon_o)
    );

    rtc_pre_tap #(.STAGES(STAGES)) i_tap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .cnt_nx_i    (cnt_nx),
        .tap_sel_i   (tap_sel_i),
        .sq_en_i     (sq_en_i),
        .raw32k_en_i (raw32k_en_i),
        .phase_i     (phase),
        .sq_wave_o   (sq_wave_o),
        .tick_o      (rate_tick_o)
    );

endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] chain_mode_i,
    input logic [3:0] tap_sel_i,
    input logic       freeze_i,
    input logic       sq_wave_o,
    input logic       rate_tick_o,
    input logic       upd_strobe_o,
    input logic       upd_soon_o
);

    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode_i != 2'b01) |=> (!rate_tick_o && !upd_strobe_o && !upd_soon_o));

    p_osc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_mode_i[0] |=> !sq_wave_o);

    p_no_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel_i == 4'd0) |=> !rate_tick_o);

    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick_o |=> !rate_tick_o);

    p_upd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe_o |=> !upd_strobe_o);

    p_soon_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe_o |-> !upd_soon_o);

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> (!upd_strobe_o && !upd_soon_o));

endmodule

bind rtc_prescaler rtc_prescaler_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chain_mode_i (chain_mode_i),
    .tap_sel_i    (tap_sel_i),
    .freeze_i     (freeze_i),
    .sq_wave_o    (sq_wave_o),
    .rate_tick_o  (rate_tick_o),
    .upd_strobe_o (upd_strobe_o),
    .upd_soon_o   (upd_soon_o)
);

// File: tb/test_rtc_prescaler.sv
module test_rtc_prescaler;

    localparam int EV_TICK = 0;
    localparam int EV_SOON = 1;
    localparam int EV_UPD  = 2;

    typedef struct {
        int kind;
        int cyc;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_edge_i = 1'b0;
    logic [1:0] chain_mode_i = 2'b00;
    logic [3:0] tap_sel_i = 4'd0;
    logic       sq_en_i = 1'b0;
    logic       raw32k_en_i = 1'b0;
    logic       freeze_i = 1'b0;
    logic       sq_wave_o, rate_tick_o, upd_strobe_o, upd_soon_o;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    int  c0 = 0;
    bit  done = 1'b0;
    bit  w_tick = 1'b0, w_soon = 1'b0, w_upd = 1'b0;
    logic soon_prev = 1'b0;
    ev_t q[$];

    rtc_prescaler i_rtc_prescaler (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_edge_i   (osc_edge_i),
        .chain_mode_i (chain_mode_i),
        .tap_sel_i    (tap_sel_i),
        .sq_en_i      (sq_en_i),
        .raw32k_en_i  (raw32k_en_i),
        .freeze_i     (freeze_i),
        .sq_wave_o    (sq_wave_o),
        .rate_tick_o  (rate_tick_o),
        .upd_strobe_o (upd_strobe_o),
        .upd_soon_o   (upd_soon_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic string ev_req(input int kind);
        if (kind == EV_TICK) return "R5";
        if (kind == EV_SOON) return "R7";
        return "R6";
    endfunction

    // monitor: every watched event must match the head of the queue
    task automatic consume(input int kind);
        ev_t e;
        if (q.size() == 0) begin
            check(1'b0, ev_req(kind), "unexpected event kind", kind, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == kind, ev_req(e.kind), "event kind", kind, e.kind);
            check(e.cyc == cyc, ev_req(e.kind), "event cycle", cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (w_tick && rate_tick_o) consume(EV_TICK);
            if (w_soon && upd_soon_o && !soon_prev) consume(EV_SOON);
            if (w_upd && upd_strobe_o) consume(EV_UPD);
            soon_prev <= upd_soon_o;
        end
    end

    task automatic push(input int kind, input int at);
        ev_t e;
        e.kind = kind;
        e.cyc  = at;
        q.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // stop, clear, then release into 01X with a strobe on every cycle
    task automatic release_chain();
        @(negedge clk);
        chain_mode_i = 2'b00;
        osc_edge_i   = 1'b1;
        @(negedge clk);
        chain_mode_i = 2'b01;
        c0 = cyc;
    endtask

    task automatic strobe_once();
        @(negedge clk);
        osc_edge_i = 1'b1;
        @(negedge clk);
        osc_edge_i = 1'b0;
    endtask

    task automatic rate_case(input logic [3:0] code, input int b, input bit en, input bit two);
        int first, half;
        tap_sel_i = code;
        sq_en_i   = en;
        release_chain();
        first = c0 + (2 << b) - 1;
        half  = 2 << b;
        push(EV_TICK, first);
        if (two) push(EV_TICK, first + (4 << b));
        w_tick = 1'b1;
        wait_until(first);
        check(sq_wave_o == en, en ? "R4" : "R5", "square wave at tap rise", sq_wave_o, en);
        wait_until(first + half);
        check(sq_wave_o == 1'b0, "R4", "square wave at tap fall", sq_wave_o, 0);
        if (two) wait_until(first + (4 << b) + 1);
        else     wait_until(first + 1);
        w_tick = 1'b0;
        check(q.size() == 0, "R5", "ticks outstanding", q.size(), 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        check(1'b0, "R6", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(sq_wave_o == 0,    "R1", "sq_wave after reset", sq_wave_o, 0);
        check(rate_tick_o == 0,  "R1", "tick after reset", rate_tick_o, 0);
        check(upd_strobe_o == 0, "R1", "update after reset", upd_strobe_o, 0);
        check(upd_soon_o == 0,   "R1", "warning after reset", upd_soon_o, 0);

        // R3 / R2: oscillator on, chain held (11X), raw 32 kHz forced
        chain_mode_i = 2'b11;
        tap_sel_i    = 4'd3;
        sq_en_i      = 1'b1;
        raw32k_en_i  = 1'b1;
        w_tick = 1'b1; w_upd = 1'b1; w_soon = 1'b1;
        for (int i = 0; i < 4; i++) begin
            strobe_once();
            check(sq_wave_o == ((i % 2) == 0), "R3", "raw 32k toggle", sq_wave_o, (i % 2) == 0);
        end
        raw32k_en_i = 1'b0;
        for (int i = 0; i < 6; i++) strobe_once();
        check(sq_wave_o == 0, "R2", "tap held under 11X", sq_wave_o, 0);

        // R3: oscillator off clears and freezes the phase
        chain_mode_i = 2'b10;
        raw32k_en_i  = 1'b1;
        for (int i = 0; i < 3; i++) begin
            strobe_once();
            check(sq_wave_o == 0, "R3", "no toggle with osc off", sq_wave_o, 0);
        end
        raw32k_en_i = 1'b0;
        w_tick = 1'b0; w_upd = 1'b0; w_soon = 1'b0;
        check(q.size() == 0, "R2", "events while held", q.size(), 0);

        // R4 / R5: tap mapping and tick period
        rate_case(4'd3, 1, 1'b1, 1'b1);
        rate_case(4'd5, 3, 1'b1, 1'b1);
        rate_case(4'd1, 6, 1'b1, 1'b1);
        rate_case(4'd2, 7, 1'b1, 1'b1);
        rate_case(4'd4, 2, 1'b0, 1'b1);
        rate_case(4'd15, 13, 1'b1, 1'b0);

        // R5: code 0 gives neither tick nor wave
        tap_sel_i = 4'd0;
        sq_en_i   = 1'b1;
        release_chain();
        w_tick = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            wait_until(c0 + 100 * i);
            check(sq_wave_o == 0, "R5", "wave with code 0", sq_wave_o, 0);
        end
        w_tick = 1'b0;
        sq_en_i = 1'b0;

        // R6 / R7: first update at half a second, then every second
        release_chain();
        push(EV_SOON, c0 + 32751);
        push(EV_UPD,  c0 + 32767);
        push(EV_SOON, c0 + 98287);
        push(EV_UPD,  c0 + 98303);
        w_soon = 1'b1; w_upd = 1'b1;
        wait_until(c0 + 32750);
        check(upd_soon_o == 0, "R7", "warning before lead", upd_soon_o, 0);
        wait_until(c0 + 32766);
        check(upd_soon_o == 1, "R7", "warning held", upd_soon_o, 1);
        wait_until(c0 + 32767);
        check(upd_soon_o == 0, "R7", "warning drops at update", upd_soon_o, 0);
        check(upd_strobe_o == 1, "R6", "first update", upd_strobe_o, 1);
        wait_until(c0 + 98305);
        check(q.size() == 0, "R6", "updates outstanding", q.size(), 0);
        w_soon = 1'b0; w_upd = 1'b0;

        // R8: freeze clears the warning and suppresses the update
        release_chain();
        push(EV_SOON, c0 + 32751);
        w_soon = 1'b1; w_upd = 1'b1;
        wait_until(c0 + 32755);
        check(upd_soon_o == 1, "R8", "warning before freeze", upd_soon_o, 1);
        freeze_i = 1'b1;
        wait_until(c0 + 32756);
        check(upd_soon_o == 0, "R8", "warning after freeze", upd_soon_o, 0);
        wait_until(c0 + 32800);
        freeze_i = 1'b0;
        wait_until(c0 + 32900);
        check(q.size() == 0 && upd_soon_o == 0, "R8", "no update while frozen", q.size(), 0);
        w_soon = 1'b0; w_upd = 1'b0;

        finish_run();
    end

endmodule